// File: doc/BRIEF.md
# Banked Internal Data Memory with Hardware Stack

This block is the 128-byte on-chip data store of a small 8-bit controller core. The lowest 32 bytes act as four groups of eight working registers, reached through a register port that combines a bank number with a register index. Sixteen bytes starting at 20h can be addressed one bit at a time, with single-bit set, clear and read. The remaining bytes are free scratch storage. A hardware stack pointer grows upward through the same array under push and pop strobes.

Four access paths share one write port on the array. When several paths request a write in the same cycle, a fixed priority picks exactly one and the others are dropped. All reads are combinational from the stored array, and writes land on the rising clock edge. The core uses the byte port for direct and indirect operands, the register port for working-register operands, the bit port for flag-style variables, and the stack strobes for calls and saves.

Top module: `dmem_banked_top`

## Requirements
- R1: A byte write at an address from 00h to 7Fh stores the data on the rising edge. A byte read of that address returns the stored value combinationally.
- R2: A byte write at an address of 80h or above changes no stored byte. A byte read at 80h or above returns 00h.
- R3: Register index n (0 to 7) with bank select b (0 to 3) addresses byte 8*b + n, for both reads and writes. That byte is also visible on the byte port.
- R4: Bit address k (00h to 7Fh) names bit (k mod 8) of byte 20h + k/8. The bit read output shows that bit.
- R5: A bit set or clear changes only the addressed bit and leaves the other seven bits of its byte unchanged. If set and clear are asserted together, set wins.
- R6: After reset every byte holds 00h, the stack pointer holds 07h and the wrap flag is low.
- R7: A push first increments the stack pointer and then writes the byte at the new address. The pop data output always shows the byte at the current pointer, and a pop decrements the pointer.
- R8: When push and pop are asserted in the same cycle, only the push takes effect.
- R9: The stack pointer stays within 00h to 7Fh and wraps modulo 128. A wrap in either direction sets a sticky wrap flag, which only reset clears.
- R10: When several writes are requested in one cycle, exactly one is performed, in this priority order: push, register, bit, byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_addr_i | input | 8 | Byte port address |
| byte_we_i | input | 1 | Byte port write strobe |
| byte_wdata_i | input | 8 | Byte port write data |
| byte_rdata_o | output | 8 | Byte port read data |
| reg_bank_i | input | 2 | Working-register bank select |
| reg_idx_i | input | 3 | Working-register index |
| reg_we_i | input | 1 | Register port write strobe |
| reg_wdata_i | input | 8 | Register port write data |
| reg_rdata_o | output | 8 | Register port read data |
| bit_addr_i | input | 7 | Bit address |
| bit_set_i | input | 1 | Set addressed bit |
| bit_clr_i | input | 1 | Clear addressed bit |
| bit_val_o | output | 1 | Value of addressed bit |
| push_i | input | 1 | Push strobe |
| push_data_i | input | 8 | Byte to push |
| pop_i | input | 1 | Pop strobe |
| pop_data_o | output | 8 | Byte at the current stack pointer |
| sp_o | output | 8 | Stack pointer |
| sp_wrap_o | output | 1 | Sticky stack wrap flag |

## Verification
A wrong bank or bit fold stores data at the wrong byte. This shows up on the byte port in the first cycle after the write, and the bench checks all 32 register slots and all 128 bit addresses for it. A read-modify-write that disturbs a neighbouring bit corrupts a preloaded byte on the next cycle. A pointer that updates in the wrong order puts pushed bytes one address off, or makes pop data lag by one entry, which the three-byte stack sequence exposes at once. A wrap or priority fault is visible on the pointer, the flag or the losing target right after the colliding edge.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  typedef logic [7:0] byte_t;
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_BYTE = 3'd1,
    SRC_BIT  = 3'd2,
    SRC_REG  = 3'd3,
    SRC_PUSH = 3'd4
  } wr_src_e;
endpackage

// File: rtl/dmem_array.sv
module dmem_array #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned NRD   = 4,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [NRD*AW-1:0] raddr_i,
  output logic [NRD*8-1:0]  rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata_o[g*8 +: 8] = mem_q[raddr_i[g*AW +: AW]];
  end

  assert_write_lands_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mem_q[$past(waddr_i)] == $past(wdata_i)));
endmodule

// File: rtl/dmem_stack_ptr.sv
module dmem_stack_ptr #(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned SP_RST = 7,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [7:0]    sp_o,
  output logic [AW-1:0] push_addr_o,
  output logic [AW-1:0] top_addr_o,
  output logic          wrap_o
);
  logic [AW-1:0] sp_q;
  logic          wrap_q;
  logic          at_top, at_bot;

  assign at_top      = (sp_q == {AW{1'b1}});
  assign at_bot      = (sp_q == '0);
  assign push_addr_o = sp_q + 1'b1;
  assign top_addr_o  = sp_q;
  assign sp_o        = 8'(sp_q);
  assign wrap_o      = wrap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q   <= AW'(SP_RST);
      wrap_q <= 1'b0;
    end else if (push_i) begin
      sp_q   <= sp_q + 1'b1;
      if (at_top) wrap_q <= 1'b1;
    end else if (pop_i) begin
      sp_q   <= sp_q - 1'b1;
      if (at_bot) wrap_q <= 1'b1;
    end
  end

  assert_sp_in_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(sp_o) < DEPTH);
  assert_wrap_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> wrap_o);
  assert_push_inc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |=> (top_addr_o == AW'($past(top_addr_o) + 1'b1)));
  assert_pop_dec_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> (top_addr_o == AW'($past(top_addr_o) - 1'b1)));
  assert_push_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> (top_addr_o == AW'($past(top_addr_o) + 1'b1)));
endmodule

// File: rtl/dmem_wr_arb.sv
module dmem_wr_arb
  import dmem_pkg::*;
#(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          push_req_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [7:0]    push_data_i,
  input  logic          reg_req_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [7:0]    reg_data_i,
  input  logic          bit_set_i,
  input  logic          bit_clr_i,
  input  logic [AW-1:0] bit_byte_addr_i,
  input  logic [2:0]    bit_pos_i,
  input  logic [7:0]    bit_cur_i,
  input  logic          byte_req_i,
  input  logic [AW-1:0] byte_addr_i,
  input  logic [7:0]    byte_data_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [7:0]    wdata_o,
  output wr_src_e       src_o
);
  logic [7:0] mask, rmw;

  assign mask = 8'b1 << bit_pos_i;
  // set dominates clear
  assign rmw  = bit_set_i ? (bit_cur_i | mask) : (bit_cur_i & ~mask);

  always_comb begin
    src_o   = SRC_NONE;
    waddr_o = '0;
    wdata_o = '0;
    if (push_req_i) begin
      src_o = SRC_PUSH; waddr_o = push_addr_i; wdata_o = push_data_i;
    end else if (reg_req_i) begin
      src_o = SRC_REG; waddr_o = reg_addr_i; wdata_o = reg_data_i;
    end else if (bit_set_i || bit_clr_i) begin
      src_o = SRC_BIT; waddr_o = bit_byte_addr_i; wdata_o = rmw;
    end else if (byte_req_i) begin
      src_o = SRC_BYTE; waddr_o = byte_addr_i; wdata_o = byte_data_i;
    end
  end
  assign we_o = (src_o != SRC_NONE);
endmodule

// File: rtl/dmem_banked_top.sv
module dmem_banked_top
  import dmem_pkg::*;
#(
  parameter int unsigned DEPTH     = 128,
  parameter int unsigned REGS      = 8,
  parameter int unsigned BANKS     = 4,
  parameter int unsigned BIT_BASE  = 32,
  parameter int unsigned BIT_BYTES = 16,
  parameter int unsigned SP_RST    = 7,
  localparam int unsigned AW       = $clog2(DEPTH),
  localparam int unsigned RIW      = $clog2(REGS),
  localparam int unsigned BKW      = $clog2(BANKS),
  localparam int unsigned BAW      = $clog2(BIT_BYTES) + 3,
  localparam int unsigned NRD      = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [7:0]     byte_addr_i,
  input  logic           byte_we_i,
  input  logic [7:0]     byte_wdata_i,
  output logic [7:0]     byte_rdata_o,
  input  logic [BKW-1:0] reg_bank_i,
  input  logic [RIW-1:0] reg_idx_i,
  input  logic           reg_we_i,
  input  logic [7:0]     reg_wdata_i,
  output logic [7:0]     reg_rdata_o,
  input  logic [BAW-1:0] bit_addr_i,
  input  logic           bit_set_i,
  input  logic           bit_clr_i,
  output logic           bit_val_o,
  input  logic           push_i,
  input  logic [7:0]     push_data_i,
  input  logic           pop_i,
  output logic [7:0]     pop_data_o,
  output logic [7:0]     sp_o,
  output logic           sp_wrap_o
);
  logic              byte_in_range;
  logic [AW-1:0]     byte_a, reg_a, bit_a, push_a, top_a, wr_a;
  logic [2:0]        bit_pos;
  logic [NRD*AW-1:0] rd_addr;
  logic [NRD*8-1:0]  rd_data;
  logic [7:0]        bit_byte, wr_d;
  logic              wr_en;
  wr_src_e           wr_src;

  assign byte_in_range = int'(byte_addr_i) < DEPTH;
  assign byte_a  = byte_addr_i[AW-1:0];
  assign reg_a   = AW'(int'(reg_bank_i) * REGS + int'(reg_idx_i));
  assign bit_a   = AW'(BIT_BASE + int'(bit_addr_i[BAW-1:3]));
  assign bit_pos = bit_addr_i[2:0];

  assign rd_addr = {top_a, bit_a, reg_a, byte_a};

  dmem_stack_ptr #(.DEPTH(DEPTH), .SP_RST(SP_RST)) u_sp (
    .clk_i, .rst_ni, .push_i, .pop_i,
    .sp_o, .push_addr_o(push_a), .top_addr_o(top_a), .wrap_o(sp_wrap_o)
  );

  dmem_wr_arb #(.DEPTH(DEPTH)) u_arb (
    .push_req_i(push_i), .push_addr_i(push_a), .push_data_i,
    .reg_req_i(reg_we_i), .reg_addr_i(reg_a), .reg_data_i(reg_wdata_i),
    .bit_set_i, .bit_clr_i, .bit_byte_addr_i(bit_a), .bit_pos_i(bit_pos),
    .bit_cur_i(bit_byte),
    .byte_req_i(byte_we_i && byte_in_range), .byte_addr_i(byte_a),
    .byte_data_i(byte_wdata_i),
    .we_o(wr_en), .waddr_o(wr_a), .wdata_o(wr_d), .src_o(wr_src)
  );

  dmem_array #(.DEPTH(DEPTH), .NRD(NRD)) u_mem (
    .clk_i, .rst_ni, .we_i(wr_en), .waddr_i(wr_a), .wdata_i(wr_d),
    .raddr_i(rd_addr), .rdata_o(rd_data)
  );

  assign byte_rdata_o = byte_in_range ? rd_data[0 +: 8] : 8'h00;
  assign reg_rdata_o  = rd_data[8 +: 8];
  assign bit_byte     = rd_data[16 +: 8];
  assign bit_val_o    = bit_byte[bit_pos];
  assign pop_data_o   = rd_data[24 +: 8];

  assert_hi_write_dropped_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_we_i && !byte_in_range) |-> (wr_src != SRC_BYTE));
  assert_push_first_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (wr_src == SRC_PUSH));
  assert_reg_over_bit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && reg_we_i) |-> (wr_src == SRC_REG));
  assert_bit_isolated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_src == SRC_BIT) |=> (!$stable(bit_addr_i) ||
      (((bit_byte ^ $past(bit_byte)) & ~(8'b1 << bit_pos)) == 8'h00)));
  assert_one_bit_moves_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_src == SRC_BIT) |=> (!$stable(bit_addr_i) ||
      $countones(bit_byte ^ $past(bit_byte)) <= 1));
endmodule

// File: tb/dmem_banked_top_bench.sv
module dmem_banked_top_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [7:0] byte_addr = '0, byte_wdata = '0, reg_wdata = '0, push_data = '0;
  logic byte_we = 1'b0, reg_we = 1'b0, bit_set = 1'b0, bit_clr = 1'b0;
  logic push = 1'b0, pop = 1'b0;
  logic [1:0] reg_bank = '0;
  logic [2:0] reg_idx = '0;
  logic [6:0] bit_addr = '0;
  logic [7:0] byte_rdata, reg_rdata, pop_data, sp;
  logic bit_val, sp_wrap;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dmem_banked_top u_dmem_banked_top (
    .clk_i(clk), .rst_ni,
    .byte_addr_i(byte_addr), .byte_we_i(byte_we), .byte_wdata_i(byte_wdata),
    .byte_rdata_o(byte_rdata),
    .reg_bank_i(reg_bank), .reg_idx_i(reg_idx), .reg_we_i(reg_we),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .bit_addr_i(bit_addr), .bit_set_i(bit_set), .bit_clr_i(bit_clr), .bit_val_o(bit_val),
    .push_i(push), .push_data_i(push_data), .pop_i(pop), .pop_data_o(pop_data),
    .sp_o(sp), .sp_wrap_o(sp_wrap)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int a);
    return 8'(a * 37 + 5);
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); @(negedge clk); rst_ni = 1'b1;
  endtask

  task automatic wr_byte(int a, logic [7:0] d);
    @(negedge clk); byte_addr = 8'(a); byte_wdata = d; byte_we = 1'b1;
    @(negedge clk); byte_we = 1'b0;
  endtask

  task automatic rd_byte(string req, int a, int exp);
    byte_addr = 8'(a); #1;
    chk(req, int'(byte_rdata), exp);
  endtask

  task automatic stack_op(bit ps, bit pp, logic [7:0] d);
    @(negedge clk); push = ps; pop = pp; push_data = d;
    @(negedge clk); push = 1'b0; pop = 1'b0;
  endtask

  task automatic bit_op(int k, bit s, bit c);
    @(negedge clk); bit_addr = 7'(k); bit_set = s; bit_clr = c;
    @(negedge clk); bit_set = 1'b0; bit_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R6: reset state
    chk("R6 sp", int'(sp), 'h07);
    chk("R6 wrap", int'(sp_wrap), 0);
    for (int a = 0; a < 128; a++) rd_byte("R6 zero", a, 0);

    // R1: full byte sweep
    for (int a = 0; a < 128; a++) wr_byte(a, pat(a));
    for (int a = 0; a < 128; a++) rd_byte("R1 readback", a, int'(pat(a)));

    // R2: upper half ignored and reads zero
    for (int a = 128; a < 256; a++) begin
      wr_byte(a, ~pat(a - 128));
      rd_byte("R2 hi read", a, 0);
    end
    for (int a = 0; a < 128; a++) rd_byte("R2 low intact", a, int'(pat(a)));

    // R3: every bank and register
    for (int b = 0; b < 4; b++) begin
      for (int n = 0; n < 8; n++) begin
        @(negedge clk); reg_bank = 2'(b); reg_idx = 3'(n);
        reg_wdata = 8'(b * 8 + n) ^ 8'hC3; reg_we = 1'b1;
        @(negedge clk); reg_we = 1'b0;
        #1 chk("R3 reg read", int'(reg_rdata), int'(8'(b * 8 + n) ^ 8'hC3));
      end
    end
    for (int a = 0; a < 32; a++) rd_byte("R3 byte view", a, int'(8'(a) ^ 8'hC3));

    // R4: every bit address
    for (int a = 32; a < 48; a++) wr_byte(a, 8'h00);
    for (int k = 0; k < 128; k++) begin
      bit_op(k, 1'b1, 1'b0);
      #1 chk("R4 bit_val", int'(bit_val), 1);
      rd_byte("R4 fold", 32 + k / 8, 1 << (k % 8));
      bit_op(k, 1'b0, 1'b1);
      rd_byte("R4 cleared", 32 + k / 8, 0);
    end

    // R5: neighbours preserved, set beats clear
    wr_byte('h24, 8'hA5);
    bit_op('h21, 1'b1, 1'b0);
    rd_byte("R5 set keeps rest", 'h24, 'hA7);
    bit_op('h27, 1'b0, 1'b1);
    rd_byte("R5 clr keeps rest", 'h24, 'h27);
    bit_op('h23, 1'b1, 1'b1);
    rd_byte("R5 set wins", 'h24, 'h2F);
    bit_addr = 7'h22; #1 chk("R5 bit read", int'(bit_val), 1);
    bit_addr = 7'h26; #1 chk("R5 bit read0", int'(bit_val), 0);

    // R7: three pushes and pops
    do_reset();
    stack_op(1'b1, 1'b0, 8'h25);
    stack_op(1'b1, 1'b0, 8'h12);
    stack_op(1'b1, 1'b0, 8'hF3);
    #1 chk("R7 sp after push", int'(sp), 'h0A);
    rd_byte("R7 slot08", 'h08, 'h25);
    rd_byte("R7 slot09", 'h09, 'h12);
    rd_byte("R7 slot0A", 'h0A, 'hF3);
    chk("R7 pop1", int'(pop_data), 'hF3);
    stack_op(1'b0, 1'b1, 8'h00);
    #1 chk("R7 pop2", int'(pop_data), 'h12);
    stack_op(1'b0, 1'b1, 8'h00);
    #1 chk("R7 pop3", int'(pop_data), 'h25);
    stack_op(1'b0, 1'b1, 8'h00);
    #1 chk("R7 sp restored", int'(sp), 'h07);

    // R8: push and pop together
    stack_op(1'b1, 1'b1, 8'h77);
    #1 chk("R8 sp", int'(sp), 'h08);
    rd_byte("R8 data", 'h08, 'h77);

    // R10: collisions, one winner
    @(negedge clk);
    push = 1'b1; push_data = 8'h11;
    reg_bank = 2'd2; reg_idx = 3'd0; reg_wdata = 8'h55; reg_we = 1'b1;
    byte_addr = 8'h40; byte_wdata = 8'h66; byte_we = 1'b1;
    @(negedge clk); push = 1'b0; reg_we = 1'b0; byte_we = 1'b0;
    rd_byte("R10 push won", 'h09, 'h11);
    rd_byte("R10 reg dropped", 'h10, 0);
    rd_byte("R10 byte dropped", 'h40, 0);
    @(negedge clk);
    reg_we = 1'b1; byte_we = 1'b1; bit_addr = 7'h00; bit_set = 1'b1;
    @(negedge clk); reg_we = 1'b0; byte_we = 1'b0; bit_set = 1'b0;
    rd_byte("R10 reg won", 'h10, 'h55);
    rd_byte("R10 bit dropped", 'h20, 0);
    rd_byte("R10 byte lost to reg", 'h40, 0);
    @(negedge clk);
    byte_addr = 8'h20; byte_wdata = 8'hF0; byte_we = 1'b1; bit_addr = 7'h00; bit_set = 1'b1;
    @(negedge clk); byte_we = 1'b0; bit_set = 1'b0;
    rd_byte("R10 bit won", 'h20, 'h01);

    // R9: wrap downward then upward
    do_reset();
    for (int i = 0; i < 7; i++) stack_op(1'b0, 1'b1, 8'h00);
    #1 chk("R9 sp at 00", int'(sp), 'h00);
    chk("R9 no wrap yet", int'(sp_wrap), 0);
    stack_op(1'b0, 1'b1, 8'h00);
    #1 chk("R9 sp wrapped down", int'(sp), 'h7F);
    chk("R9 wrap flag down", int'(sp_wrap), 1);
    do_reset();
    for (int i = 0; i < 120; i++) stack_op(1'b1, 1'b0, 8'(i));
    #1 chk("R9 sp at 7F", int'(sp), 'h7F);
    chk("R9 no wrap at top", int'(sp_wrap), 0);
    stack_op(1'b1, 1'b0, 8'hBE);
    #1 chk("R9 sp wrapped up", int'(sp), 'h00);
    chk("R9 wrap flag up", int'(sp_wrap), 1);
    rd_byte("R9 data at 00", 'h00, 'hBE);
    stack_op(1'b0, 1'b1, 8'h00);
    #1 chk("R9 flag sticky", int'(sp_wrap), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule